// File: doc/BRIEF.md
# Grouped Priority Interrupt Arbiter

This block arbitrates 64 interrupt inputs for a processor core that supports nested handlers. Each interrupt has an enable bit, a pending bit, an active bit and a priority. Of the 8-bit priority byte, only the upper 4 bits are stored. A 3-bit grouping value splits the stored priority into two parts. The upper part is the group priority, and it decides pre-emption. The lower part is the sub-priority, and it only orders pending requests within the same group.

In every cycle the arbiter picks the most urgent candidate, meaning an interrupt that is both enabled and pending. It raises a take request when nothing is running, or when the candidate's group priority is strictly more urgent than the current execution priority. The core answers with an entry pulse when it starts the handler and an exit pulse when it returns. The arbiter keeps a small stack so that each exit retires the handler entered most recently.

Software writes the arrays through a single configuration port. Enable and pending each have separate set and clear operations, and in those operations only the 1 bits of the data act.

Top module: `group_prio_arbiter`

## Requirements
- R1: Configuration writes use `cfg_kind` 0 = set-enable, 1 = clear-enable, 2 = set-pending and 3 = clear-pending. Each write addresses the 32-bit word `cfg_index[0]` (interrupt n sits at word n/32, bit n%32). A 1 bit sets or clears the matching interrupt, and a 0 bit leaves it unchanged. Reading kinds 0/1 returns the enable word, and reading kinds 2/3 returns the pending word.
- R2: Kind 4 reads the active word. Writes to kind 4 change nothing, and the active bits change only on an accepted entry or exit.
- R3: Kind 5 addresses interrupt `cfg_index`. A write stores `cfg_wdata[7:4]`, and a read returns that nibble in bits [7:4] with bits [3:0] always 0.
- R4: Kind 6 holds the 3-bit grouping value in bits [2:0]. Values 7, 6, 5, 4 and 3 give 0, 1, 2, 3 and 4 group bits, taken from the top of the stored nibble. Values 0 to 2 act like 3. The remaining bits are sub-priority.
- R5: An interrupt is a candidate only if both its enable bit and its pending bit are set. The winner is the candidate with the lowest group value, then the lowest sub-priority, then the lowest interrupt number. It appears on `take_id`, with its priority byte on `take_prio`.
- R6: `take_req` is high only when there is a candidate and either no interrupt is active or the winner's group is numerically lower than `exec_prio`. Sub-priority never allows pre-emption.
- R7: A 0-to-1 change of `irq_in[n]`, seen at a clock edge, sets pending bit n at that edge. An input that stays high, or stays low, sets nothing.
- R8: `entry_ack` while `take_req` is high, and `exit_ack` is low, sets the active bit and clears the pending bit of `take_id` at that edge. It also pushes `take_id` onto the nesting stack.
- R9: `exit_ack` with a non-empty stack clears the active bit of the interrupt entered most recently and pops it from the stack.
- R10: If `irq_in[n]` is still high when interrupt n exits, pending bit n is set again at that same exit edge.
- R11: `exec_valid` is high exactly when some active bit is set. `exec_prio` is then the lowest group value among the active interrupts, and it is all ones when none is active. After reset all bits, priorities and the grouping are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 64 | Interrupt request lines |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 3 | Selects the array that is read or written |
| cfg_index | input | 6 | Word number (bit 0) or interrupt number |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for the current kind and index |
| entry_ack | input | 1 | Core enters the handler of `take_id` |
| exit_ack | input | 1 | Core returns from the current handler |
| take_req | output | 1 | A candidate may pre-empt |
| take_id | output | 6 | Winning interrupt number |
| take_prio | output | 8 | Winner's priority byte |
| exec_valid | output | 1 | At least one handler is active |
| exec_prio | output | 4 | Current execution group priority |

## Verification
In every cycle the in-line assertions check the following:
- the granted interrupt is enabled and pending;
- a take request made while a handler runs carries a strictly more urgent group;
- the active set is stable unless an entry or exit happens;
- an entry marks its interrupt active;
- an exit retires exactly one interrupt;
- the nesting stack never overflows.

Other behaviour only shows in the bench scenarios:
- the ordering among several candidates under different groupings;
- that a same-group request with a better sub-priority waits;
- the last-in-first-out retirement order;
- edge versus level behaviour of the request lines;
- the write-one semantics.

// File: rtl/group_prio_arbiter.sv
module group_prio_arbiter #(
  parameter int NUM_IRQ    = 64,
  parameter int PRIO_BITS  = 4,
  parameter int NEST_DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_IRQ-1:0]         irq_in,
  input  logic                       cfg_we,
  input  logic [2:0]                 cfg_kind,
  input  logic [$clog2(NUM_IRQ)-1:0] cfg_index,
  input  logic [31:0]                cfg_wdata,
  output logic [31:0]                cfg_rdata,
  input  logic                       entry_ack,
  input  logic                       exit_ack,
  output logic                       take_req,
  output logic [$clog2(NUM_IRQ)-1:0] take_id,
  output logic [7:0]                 take_prio,
  output logic                       exec_valid,
  output logic [PRIO_BITS-1:0]       exec_prio
);
  localparam int WORDS = NUM_IRQ / 32;
  localparam int WW    = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int IDW   = $clog2(NUM_IRQ);
  localparam int DW    = $clog2(NEST_DEPTH + 1);
  localparam int SW    = (NEST_DEPTH > 1) ? $clog2(NEST_DEPTH) : 1;

  logic [NUM_IRQ-1:0]   en_q, pend_q, act_q, irq_q;
  logic [PRIO_BITS-1:0] prio_q [NUM_IRQ];
  logic [2:0]           grp_q;
  logic [IDW-1:0]       stk_q [NEST_DEPTH];
  logic [DW-1:0]        depth_q;

  logic [NUM_IRQ-1:0] wmask;
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign wmask[w*32 +: 32] = (cfg_we && cfg_index[WW-1:0] == WW'(w)) ? cfg_wdata : 32'd0;
  end

  int pbits;
  logic [PRIO_BITS-1:0] gmask;
  always_comb begin
    if (grp_q >= 3'd3 && (7 - int'(grp_q)) <= PRIO_BITS) pbits = 7 - int'(grp_q);
    else pbits = PRIO_BITS;
    gmask = ~({PRIO_BITS{1'b1}} >> pbits);
  end

  logic                 best_ok, ex_ok;
  logic [IDW-1:0]       best_id;
  logic [PRIO_BITS-1:0] best_p, ex_p, take_grp;
  always_comb begin
    best_ok = 1'b0;
    best_id = '0;
    best_p  = '1;
    ex_ok   = 1'b0;
    ex_p    = '1;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (en_q[i] && pend_q[i] && (!best_ok || prio_q[i] < best_p)) begin
        best_ok = 1'b1;
        best_id = IDW'(i);
        best_p  = prio_q[i];
      end
      if (act_q[i] && (!ex_ok || (prio_q[i] & gmask) < ex_p)) begin
        ex_ok = 1'b1;
        ex_p  = prio_q[i] & gmask;
      end
    end
  end

  assign take_grp   = best_p & gmask;
  assign take_req   = best_ok && (!ex_ok || take_grp < ex_p);
  assign take_id    = best_id;
  assign take_prio  = {best_p, {(8-PRIO_BITS){1'b0}}};
  assign exec_valid = ex_ok;
  assign exec_prio  = ex_p;

  logic           do_entry, do_exit;
  logic [DW-1:0]  top_ptr;
  logic [IDW-1:0] top_id;
  logic [NUM_IRQ-1:0] entry_vec, exit_vec, pend_set, pend_clr;
  assign do_entry  = entry_ack && take_req && !exit_ack;
  assign do_exit   = exit_ack && (depth_q != '0);
  assign top_ptr   = depth_q - DW'(1);
  assign top_id    = stk_q[top_ptr[SW-1:0]];
  assign entry_vec = do_entry ? (NUM_IRQ'(1) << take_id) : '0;
  assign exit_vec  = do_exit  ? (NUM_IRQ'(1) << top_id)  : '0;
  assign pend_set  = ((cfg_kind == 3'd2) ? wmask : '0) | (irq_in & ~irq_q) | (irq_in & exit_vec);
  assign pend_clr  = ((cfg_kind == 3'd3) ? wmask : '0) | entry_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= '0;
      pend_q  <= '0;
      act_q   <= '0;
      irq_q   <= '0;
      grp_q   <= '0;
      depth_q <= '0;
      for (int i = 0; i < NUM_IRQ; i++) prio_q[i] <= '0;
      for (int i = 0; i < NEST_DEPTH; i++) stk_q[i] <= '0;
    end else begin
      irq_q  <= irq_in;
      en_q   <= (en_q & ~((cfg_kind == 3'd1) ? wmask : '0)) | ((cfg_kind == 3'd0) ? wmask : '0);
      pend_q <= (pend_q & ~pend_clr) | pend_set;
      act_q  <= (act_q | entry_vec) & ~exit_vec;
      if (cfg_we && cfg_kind == 3'd5) prio_q[cfg_index] <= cfg_wdata[7 -: PRIO_BITS];
      if (cfg_we && cfg_kind == 3'd6) grp_q <= cfg_wdata[2:0];
      if (do_entry) begin
        stk_q[depth_q[SW-1:0]] <= take_id;
        depth_q <= depth_q + DW'(1);
      end else if (do_exit) begin
        depth_q <= top_ptr;
      end
    end
  end

  int rw;
  always_comb begin
    rw = int'(cfg_index[WW-1:0]);
    if (rw >= WORDS) rw = 0;
    case (cfg_kind)
      3'd0, 3'd1: cfg_rdata = en_q[rw*32 +: 32];
      3'd2, 3'd3: cfg_rdata = pend_q[rw*32 +: 32];
      3'd4:       cfg_rdata = act_q[rw*32 +: 32];
      3'd5:       cfg_rdata = {24'd0, prio_q[cfg_index], {(8-PRIO_BITS){1'b0}}};
      3'd6:       cfg_rdata = {29'd0, grp_q};
      default:    cfg_rdata = 32'd0;
    endcase
  end

  assert_take_is_candidate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    take_req |-> (en_q[take_id] && pend_q[take_id]));

  assert_preempt_strict_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_req && exec_valid) |-> ((take_prio[7 -: PRIO_BITS] & gmask) < exec_prio));

  assert_active_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!entry_ack && !exit_ack) |=> $stable(act_q));

  assert_entry_marks_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_ack && take_req && !exit_ack) |=> act_q[$past(take_id)]);

  assert_exit_retires_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_ack && depth_q != '0) |=> ($countones(act_q) == $past($countones(act_q)) - 1));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_ack && take_req && !exit_ack) |-> (depth_q < DW'(NEST_DEPTH)));

  assert_idle_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    exec_valid == (act_q != '0));
endmodule

// File: tb/group_prio_arbiter_test.sv
module group_prio_arbiter_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, cfg_we, entry_ack, exit_ack, take_req, exec_valid;
  logic [63:0] irq_in;
  logic [2:0]  cfg_kind;
  logic [5:0]  cfg_index, take_id;
  logic [31:0] cfg_wdata, cfg_rdata, rv;
  logic [7:0]  take_prio;
  logic [3:0]  exec_prio;

  group_prio_arbiter uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_index(cfg_index), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .entry_ack(entry_ack), .exit_ack(exit_ack), .take_req(take_req), .take_id(take_id),
    .take_prio(take_prio), .exec_valid(exec_valid), .exec_prio(exec_prio));

  int checks = 0, fails = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] k, input logic [5:0] idx, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_kind = k; cfg_index = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] k, input logic [5:0] idx, output logic [31:0] d);
    cfg_kind = k; cfg_index = idx;
    #1 d = cfg_rdata;
  endtask

  task automatic bit_op(input logic [2:0] k, input logic [5:0] id);
    wr(k, {5'd0, id[5]}, 32'd1 << id[4:0]);
  endtask

  task automatic do_entry();
    @(negedge clk); entry_ack = 1'b1;
    @(negedge clk); entry_ack = 1'b0;
  endtask

  task automatic do_exit();
    @(negedge clk); exit_ack = 1'b1;
    @(negedge clk); exit_ack = 1'b0;
  endtask

  // [28:23] id a, [22:19] prio a, [18:13] id b, [12:9] prio b, [8:6] grouping, [5:0] expected winner
  localparam logic [31:0] VEC [6] = '{
    {3'd0, 6'd5,  4'd3,  6'd40, 4'd2,  3'd3, 6'd40},
    {3'd0, 6'd5,  4'd2,  6'd40, 4'd2,  3'd3, 6'd5},
    {3'd0, 6'd33, 4'd8,  6'd2,  4'd9,  3'd7, 6'd33},
    {3'd0, 6'd10, 4'd4,  6'd3,  4'd5,  3'd5, 6'd10},
    {3'd0, 6'd63, 4'd0,  6'd0,  4'd1,  3'd4, 6'd63},
    {3'd0, 6'd20, 4'd15, 6'd21, 4'd15, 3'd6, 6'd20}
  };

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_kind = '0; cfg_index = '0; cfg_wdata = '0;
    entry_ack = 1'b0; exit_ack = 1'b0; irq_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk("R11 reset take_req", {31'd0, take_req}, 32'd0);
    chk("R11 reset exec_valid", {31'd0, exec_valid}, 32'd0);
    chk("R11 reset exec_prio", {28'd0, exec_prio}, 32'hF);
    rd(3'd0, 6'd0, rv); chk("R11 reset enable word", rv, 32'd0);
    rd(3'd6, 6'd0, rv); chk("R11 reset grouping", rv, 32'd0);

    // R5 R4 arbitration table
    foreach (VEC[v]) begin
      wr(3'd6, 6'd0, {29'd0, VEC[v][8:6]});
      rd(3'd6, 6'd0, rv); chk("R4 grouping readback", rv, {29'd0, VEC[v][8:6]});
      wr(3'd5, VEC[v][28:23], {24'd0, VEC[v][22:19], 4'd0});
      wr(3'd5, VEC[v][18:13], {24'd0, VEC[v][12:9], 4'd0});
      bit_op(3'd0, VEC[v][28:23]); bit_op(3'd0, VEC[v][18:13]);
      bit_op(3'd2, VEC[v][28:23]); bit_op(3'd2, VEC[v][18:13]);
      chk("R5 table take_req", {31'd0, take_req}, 32'd1);
      chk("R5 table winner", {26'd0, take_id}, {26'd0, VEC[v][5:0]});
      bit_op(3'd3, VEC[v][28:23]); bit_op(3'd3, VEC[v][18:13]);
      bit_op(3'd1, VEC[v][28:23]); bit_op(3'd1, VEC[v][18:13]);
      chk("R5 no candidate", {31'd0, take_req}, 32'd0);
    end

    // R1 write-one semantics
    wr(3'd0, 6'd0, 32'hF0);
    wr(3'd0, 6'd0, 32'h0);
    rd(3'd0, 6'd0, rv); chk("R1 zero set ignored", rv, 32'hF0);
    wr(3'd1, 6'd0, 32'h10);
    rd(3'd1, 6'd0, rv); chk("R1 clear one bit", rv, 32'hE0);
    wr(3'd1, 6'd0, 32'h0);
    rd(3'd0, 6'd0, rv); chk("R1 zero clear ignored", rv, 32'hE0);
    wr(3'd2, 6'd1, 32'h8000_0000);
    rd(3'd2, 6'd1, rv); chk("R1 pending word1 bit31", rv, 32'h8000_0000);
    chk("R1 disabled not taken", {31'd0, take_req}, 32'd0);
    wr(3'd3, 6'd1, 32'hFFFF_FFFF);
    wr(3'd1, 6'd0, 32'hFFFF_FFFF);

    // R3 priority byte
    wr(3'd5, 6'd7, 32'hAB);
    rd(3'd5, 6'd7, rv); chk("R3 low nibble reads zero", rv, 32'hA0);
    wr(3'd5, 6'd7, 32'h0);

    // R2 active read-only
    wr(3'd4, 6'd0, 32'hFFFF_FFFF);
    rd(3'd4, 6'd0, rv); chk("R2 active write ignored", rv, 32'd0);

    // R6 R8 R9 R11 nesting, grouping 5: two group bits
    wr(3'd6, 6'd0, 32'd5);
    wr(3'd5, 6'd1, 32'h80); wr(3'd5, 6'd2, 32'h90); wr(3'd5, 6'd3, 32'h40);
    wr(3'd0, 6'd0, 32'hE);
    bit_op(3'd2, 6'd2);
    chk("R5 single candidate id", {26'd0, take_id}, 32'd2);
    chk("R5 take_prio byte", {24'd0, take_prio}, 32'h90);
    do_entry();
    rd(3'd4, 6'd0, rv); chk("R8 active after entry", rv, 32'h4);
    rd(3'd2, 6'd0, rv); chk("R8 pending cleared", rv, 32'h0);
    chk("R11 exec_prio group", {28'd0, exec_prio}, 32'h8);
    bit_op(3'd2, 6'd1);
    chk("R6 same group no preempt", {31'd0, take_req}, 32'd0);
    bit_op(3'd2, 6'd3);
    chk("R6 better group preempts", {31'd0, take_req}, 32'd1);
    chk("R6 preempt id", {26'd0, take_id}, 32'd3);
    do_entry();
    chk("R11 nested exec_prio", {28'd0, exec_prio}, 32'h4);
    do_exit();
    rd(3'd4, 6'd0, rv); chk("R9 last entered retired", rv, 32'h4);
    chk("R9 exec_prio restored", {28'd0, exec_prio}, 32'h8);
    chk("R6 still blocked", {31'd0, take_req}, 32'd0);
    do_exit();
    chk("R11 idle after exits", {31'd0, exec_valid}, 32'd0);
    chk("R6 idle takes waiting", {26'd0, take_id}, 32'd1);
    do_entry();
    do_exit();
    wr(3'd1, 6'd0, 32'hE);

    // R7 R10 request lines
    wr(3'd5, 6'd40, 32'h30);
    bit_op(3'd0, 6'd40);
    @(negedge clk); irq_in[40] = 1'b1;
    @(negedge clk);
    rd(3'd2, 6'd1, rv); chk("R7 rising edge pends", rv, 32'h100);
    chk("R7 taken", {26'd0, take_id}, 32'd40);
    do_entry();
    rd(3'd2, 6'd1, rv); chk("R7 held high no repend", rv, 32'h0);
    do_exit();
    rd(3'd2, 6'd1, rv); chk("R10 level repends on exit", rv, 32'h100);
    irq_in[40] = 1'b0;
    bit_op(3'd3, 6'd40);
    repeat (2) @(negedge clk);
    rd(3'd2, 6'd1, rv); chk("R7 low level no pend", rv, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule